// File: doc/BRIEF.md
# Dictionary Packet Instruction Expander

This unit sits on the instruction path between an instruction cache and a processor fetch stage. Each 32-bit word taken from the cache is either an ordinary instruction, which goes through unchanged, or a compressed packet. A word is a packet when its top five bits are all zero; such a word carries two or three 8-bit indices into a 256-entry table of full 32-bit instructions. The unit looks up each index and hands the processor one full instruction per cycle, in slot order.

Each accepted word is kept in a one-word local buffer. The second and third instructions of a packet are read from that buffer, so the cache is asked for a word only once per packet. While slots remain, the cache request is held low. After a taken branch the processor pulses a redirect input. This drops every instruction not yet presented and any buffered slots. The first word accepted after it then begins at the slot named by its own entry field, so a branch target may sit in the middle of a packet.

The table is filled through a plain write port. Lookups use a registered read, so the table maps onto block RAM. Every word, compressed or not, reaches the output two rising edges after the edge that accepts it.

Top module: `ipk_expander`

## Requirements
- R1: While `rst` is high, `instr_valid` and `fetch_req` are 0. On the first rising edge after `rst` falls, `fetch_req` goes to 1.
- R2: A word is accepted on a rising edge where `fetch_req`, `rsp_valid` are 1 and `redirect` is 0. An accepted word whose bits 31:27 are not all zero appears unchanged on `instr_data`, with `instr_valid` high, two rising edges after the accepting edge.
- R3: An accepted word with bits 31:27 zero and bit 26 = 0 is a three-slot packet. It yields table[bits 23:16], table[bits 15:8] and table[bits 7:0] in that order. These appear on consecutive cycles, the first two edges after acceptance.
- R4: For a packet with bit 26 = 1, only the slots in bits 23:16 and 15:8 are issued. Bits 7:0 have no effect, and the next word follows directly.
- R5: While slots of a buffered packet remain to be issued, `fetch_req` is 0. It returns to 1 on the edge that issues the last slot, so each packet costs exactly one accepted word.
- R6: For the first word accepted after a redirect, bits 25:24 give the starting slot: 0 = bits 23:16, 1 = bits 15:8, 2 = bits 7:0. Every other accepted packet starts at bits 23:16, and its bits 25:24 are ignored.
- R7: If the starting slot lies past the last valid slot, the packet issues nothing. This covers a value of 2 with bit 26 = 1, and a value of 3 in either case.
- R8: On a rising edge where `redirect` is 1, three things happen. No word is accepted. Any remaining buffered slots are discarded. `instr_valid` is 0 after that edge, and `fetch_req` is 1 after it.
- R9: On a rising edge where `dict_we` is 1, `dict_wdata` is stored at table index `dict_waddr`. Later lookups of that index return the new value.
- R10: Back-to-back accepted words and the slots of a packet come out at one instruction per cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | output | 1 | Unit can take a word from the cache this cycle |
| rsp_valid | input | 1 | Cache presents a word on `rsp_word` |
| rsp_word | input | 32 | Word from the instruction cache |
| redirect | input | 1 | Taken branch: squash and arm slot entry |
| dict_we | input | 1 | Table write enable |
| dict_waddr | input | 8 | Table write index |
| dict_wdata | input | 32 | Table write data |
| instr_valid | output | 1 | `instr_data` holds an instruction for fetch |
| instr_data | output | 32 | Expanded or forwarded instruction |

## Verification
The bench builds the unit with its default 32-bit word and 5-bit sentinel, which gives 8-bit indices and a full 256-entry table. Every table index can therefore be written and read back. Every legal and illegal entry value, and both slot counts, can be applied to real packets. A scoreboard queue predicts each instruction, and cycle-exact probes of `fetch_req` and `instr_valid` cover the buffer hold-off, the one-per-cycle rate and a redirect arriving in the middle of a packet.

// File: rtl/ipk_pkg.sv
package ipk_pkg;
  localparam int NSLOT   = 3;
  localparam int ENTRY_W = 2;

  typedef logic [ENTRY_W-1:0] slot_idx_t;

  // last valid slot number for a packet, given its two-slot flag
  function automatic slot_idx_t last_slot(input logic two_only);
    return two_only ? slot_idx_t'(1) : slot_idx_t'(2);
  endfunction
endpackage

// File: rtl/ipk_dict_ram.sv
module ipk_dict_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ipk_slot_seq.sv
module ipk_slot_seq
  import ipk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SENT_W = 5,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_word,
  input  logic              redirect,
  output logic              fetch_req,
  output logic              entry_armed,
  output logic [IDX_W-1:0]  rd_addr,
  output logic              iss_valid,
  output logic              iss_pkt,
  output logic [WORD_W-1:0] iss_raw
);
  localparam int CNT_BIT = WORD_W - SENT_W - 1;
  localparam int ENT_HI  = CNT_BIT - 1;

  logic [WORD_W-1:0] hold_q;
  slot_idx_t         last_q, nxt_q, nxt_n;
  logic              busy_q, busy_n, armed_n;
  logic              take_word, word_is_pkt, iss_v, iss_p;
  slot_idx_t         start_c, last_c;
  logic [IDX_W-1:0]  new_slot  [NSLOT];
  logic [IDX_W-1:0]  held_slot [NSLOT];

  // slot 0 is the most significant index field
  for (genvar g = 0; g < NSLOT; g++) begin : g_slots
    assign new_slot[g]  = rsp_word[(NSLOT-g)*IDX_W-1 -: IDX_W];
    assign held_slot[g] = hold_q[(NSLOT-g)*IDX_W-1 -: IDX_W];
  end

  assign take_word   = fetch_req && rsp_valid && !redirect;
  assign word_is_pkt = (rsp_word[WORD_W-1 -: SENT_W] == '0);
  assign last_c      = last_slot(rsp_word[CNT_BIT]);
  assign start_c     = entry_armed ? rsp_word[ENT_HI -: ENTRY_W] : slot_idx_t'(0);

  always_comb begin
    busy_n  = busy_q;
    nxt_n   = nxt_q;
    armed_n = entry_armed;
    iss_v   = 1'b0;
    iss_p   = 1'b0;
    rd_addr = '0;
    if (redirect) begin
      busy_n  = 1'b0;
      armed_n = 1'b1;
    end else if (busy_q) begin
      iss_v   = 1'b1;
      iss_p   = 1'b1;
      rd_addr = held_slot[nxt_q];
      if (nxt_q == last_q) busy_n = 1'b0;
      else                 nxt_n  = slot_idx_t'(nxt_q + 1'b1);
    end else if (take_word) begin
      armed_n = 1'b0;
      if (!word_is_pkt) begin
        iss_v = 1'b1;
      end else if (start_c <= last_c) begin
        iss_v   = 1'b1;
        iss_p   = 1'b1;
        rd_addr = new_slot[start_c];
        if (start_c != last_c) begin
          busy_n = 1'b1;
          nxt_n  = slot_idx_t'(start_c + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      nxt_q       <= '0;
      entry_armed <= 1'b0;
      fetch_req   <= 1'b0;
      iss_valid   <= 1'b0;
      iss_pkt     <= 1'b0;
    end else begin
      busy_q      <= busy_n;
      nxt_q       <= nxt_n;
      entry_armed <= armed_n;
      fetch_req   <= !busy_n;
      iss_valid   <= iss_v;
      iss_pkt     <= iss_p;
    end
  end

  // local one-word buffer, refreshed on every accepted word
  always_ff @(posedge clk) begin
    if (take_word) begin
      hold_q <= rsp_word;
      last_q <= last_c;
    end
    iss_raw <= rsp_word;
  end
endmodule

// File: rtl/ipk_out_stage.sv
module ipk_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redirect,
  input  logic              iss_valid,
  input  logic              iss_pkt,
  input  logic [WORD_W-1:0] iss_raw,
  input  logic [WORD_W-1:0] dict_q,
  output logic              instr_valid,
  output logic [WORD_W-1:0] instr_data
);
  always_ff @(posedge clk) begin
    if (rst) instr_valid <= 1'b0;
    else     instr_valid <= iss_valid && !redirect;
  end

  always_ff @(posedge clk) begin
    instr_data <= iss_pkt ? dict_q : iss_raw;
  end
endmodule

// File: rtl/ipk_expander.sv
module ipk_expander #(
  parameter int WORD_W = 32,
  parameter int SENT_W = 5
) (
  input  logic                                 clk,
  input  logic                                 rst,
  output logic                                 fetch_req,
  input  logic                                 rsp_valid,
  input  logic [WORD_W-1:0]                    rsp_word,
  input  logic                                 redirect,
  input  logic                                 dict_we,
  input  logic [(WORD_W-SENT_W-3)/3-1:0]       dict_waddr,
  input  logic [WORD_W-1:0]                    dict_wdata,
  output logic                                 instr_valid,
  output logic [WORD_W-1:0]                    instr_data
);
  localparam int IDX_W = (WORD_W - SENT_W - 3) / 3;

  logic              entry_armed;
  logic [IDX_W-1:0]  rd_addr;
  logic              iss_valid, iss_pkt;
  logic [WORD_W-1:0] iss_raw, dict_q;

  ipk_slot_seq #(.WORD_W(WORD_W), .SENT_W(SENT_W), .IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .redirect(redirect), .fetch_req(fetch_req), .entry_armed(entry_armed),
    .rd_addr(rd_addr), .iss_valid(iss_valid), .iss_pkt(iss_pkt),
    .iss_raw(iss_raw)
  );

  ipk_dict_ram #(.AW(IDX_W), .DW(WORD_W)) dict_i (
    .clk(clk), .we(dict_we), .waddr(dict_waddr), .wdata(dict_wdata),
    .raddr(rd_addr), .rdata(dict_q)
  );

  ipk_out_stage #(.WORD_W(WORD_W)) out_i (
    .clk(clk), .rst(rst), .redirect(redirect), .iss_valid(iss_valid),
    .iss_pkt(iss_pkt), .iss_raw(iss_raw), .dict_q(dict_q),
    .instr_valid(instr_valid), .instr_data(instr_data)
  );
endmodule

// File: rtl/ipk_expander_chk.sv
module ipk_expander_chk #(
  parameter int WORD_W = 32,
  parameter int SENT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_req,
  input logic              rsp_valid,
  input logic [WORD_W-1:0] rsp_word,
  input logic              redirect,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr_data,
  input logic              entry_armed
);
  localparam int CNT_BIT = WORD_W - SENT_W - 1;

  logic       acc, pkt, two_only, rst_d;
  logic [1:0] entry;

  assign acc      = fetch_req && rsp_valid && !redirect;
  assign pkt      = (rsp_word[WORD_W-1 -: SENT_W] == '0);
  assign two_only = rsp_word[CNT_BIT];
  assign entry    = rsp_word[CNT_BIT-1 -: 2];

  initial rst_d = 1'b0;
  always @(posedge clk) rst_d <= rst;

  // R1: outputs idle after any reset edge
  always @(posedge clk) begin
    if (rst_d) a_r1_reset_idle: assert (!instr_valid && !fetch_req);
  end

  a_r2_raw_forward: assert property (@(posedge clk) disable iff (rst)
    (acc && !pkt) ##1 !redirect |=> instr_valid && instr_data == $past(rsp_word, 2));

  a_r5_hold_fetch: assert property (@(posedge clk) disable iff (rst)
    (acc && pkt && !entry_armed) |=> !fetch_req);

  a_r4_two_slot_span: assert property (@(posedge clk) disable iff (rst)
    (acc && pkt && two_only && !entry_armed) |=> !fetch_req ##1 fetch_req);

  a_r7_bad_entry: assert property (@(posedge clk) disable iff (rst)
    (acc && pkt && entry_armed && (entry == 2'd3 || (two_only && entry == 2'd2)))
      ##1 !redirect |=> !instr_valid);

  a_r8_squash: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !instr_valid && fetch_req);
endmodule

bind ipk_expander ipk_expander_chk #(.WORD_W(WORD_W), .SENT_W(SENT_W)) chk_i (
  .clk(clk), .rst(rst), .fetch_req(fetch_req), .rsp_valid(rsp_valid),
  .rsp_word(rsp_word), .redirect(redirect), .instr_valid(instr_valid),
  .instr_data(instr_data), .entry_armed(entry_armed)
);

// File: tb/ipk_expander_tb_top.sv
`timescale 1ns/1ps
module ipk_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req, rsp_valid = 1'b0, redirect = 1'b0, dict_we = 1'b0;
  logic [31:0] rsp_word = '0, dict_wdata = '0, instr_data;
  logic [7:0]  dict_waddr = '0;
  logic        instr_valid;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t        sb[$];
  logic [31:0] model [256];
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ipk_expander dut_i (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .redirect(redirect), .dict_we(dict_we),
    .dict_waddr(dict_waddr), .dict_wdata(dict_wdata),
    .instr_valid(instr_valid), .instr_data(instr_data)
  );

  function automatic logic [31:0] pkt(input bit two, input logic [1:0] ent,
                                      input logic [7:0] a, b, c);
    return {5'b0, two, ent, a, b, c};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // driver: present one word once the unit asks for it
  task automatic send(input logic [31:0] w);
    while (!fetch_req) @(negedge clk);
    rsp_valid = 1'b1; rsp_word = w;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic do_redirect();
    redirect = 1'b1;
    @(negedge clk);
    redirect = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    check(sb.size() == 0, tag, 32'(sb.size()), 32'd0);
    sb.delete();
  endtask

  // monitor: compare every produced instruction against the queue
  always @(negedge clk) begin
    if (!rst && instr_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "unexpected output", instr_data, 32'hxxxxxxxx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(instr_data === e.v, e.tag, instr_data, e.v);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired got %h exp %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9: load the table during reset
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      model[i]   = {8'(i) ^ 8'h3C, 8'hD1, 8'(i), ~8'(i)};
      dict_we    = 1'b1;
      dict_waddr = 8'(i);
      dict_wdata = model[i];
    end
    @(negedge clk);
    dict_we = 1'b0;
    check(!instr_valid && !fetch_req, "R1 idle in reset", {30'd0, instr_valid, fetch_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(fetch_req === 1'b1, "R1 request after reset", {31'd0, fetch_req}, 32'd1);

    // R2: pass-through and its latency
    push(32'hDEADBEEF, "R2 raw word");
    send(32'hDEADBEEF);
    check(!instr_valid, "R2 not yet out", {31'd0, instr_valid}, 32'd0);
    @(negedge clk);
    check(instr_valid === 1'b1, "R2 out after two edges", {31'd0, instr_valid}, 32'd1);
    drain("R2 drained");

    // R10: back-to-back raw words
    push(32'h8000_0001, "R10 raw 1");
    push(32'h4000_0002, "R10 raw 2");
    push(32'h0800_0003, "R10 raw 3");
    send(32'h8000_0001);
    send(32'h4000_0002);
    send(32'h0800_0003);
    check(instr_valid === 1'b1, "R10 continuous raw", {31'd0, instr_valid}, 32'd1);
    drain("R10 drained");

    // R3, R5, R10: three-slot packet timing
    push(model[8'h11], "R3 slot A");
    push(model[8'hA2], "R3 slot B");
    push(model[8'hF3], "R3 slot C");
    send(pkt(1'b0, 2'd0, 8'h11, 8'hA2, 8'hF3));
    check(!fetch_req, "R5 hold after accept", {31'd0, fetch_req}, 32'd0);
    @(negedge clk);
    check(!fetch_req && instr_valid, "R5 hold while B pending",
          {30'd0, fetch_req, instr_valid}, 32'd1);
    @(negedge clk);
    check(fetch_req && instr_valid, "R5 request on last slot",
          {30'd0, fetch_req, instr_valid}, 32'd3);
    @(negedge clk);
    check(instr_valid === 1'b1, "R10 slot C no gap", {31'd0, instr_valid}, 32'd1);
    drain("R3 drained");

    // R4: two-slot packet, third field ignored, next word directly after
    push(model[8'h05], "R4 slot A");
    push(model[8'h06], "R4 slot B");
    push(32'h1234_5678, "R4 following word");
    send(pkt(1'b1, 2'd0, 8'h05, 8'h06, 8'h07));
    send(32'h1234_5678);
    drain("R4 drained");

    // R6: entry slots after redirect
    do_redirect();
    push(model[8'h22], "R6 entry 1 first");
    push(model[8'h33], "R6 entry 1 second");
    send(pkt(1'b0, 2'd1, 8'h21, 8'h22, 8'h33));
    drain("R6 entry 1 drained");
    do_redirect();
    push(model[8'h99], "R6 entry 2");
    send(pkt(1'b0, 2'd2, 8'h97, 8'h98, 8'h99));
    drain("R6 entry 2 drained");
    do_redirect();
    push(model[8'h42], "R6 two-slot entry 1");
    send(pkt(1'b1, 2'd1, 8'h41, 8'h42, 8'h43));
    drain("R6 two-slot drained");
    push(model[8'h51], "R6 unarmed starts at A");
    push(model[8'h52], "R6 unarmed B");
    push(model[8'h53], "R6 unarmed C");
    send(pkt(1'b0, 2'd2, 8'h51, 8'h52, 8'h53));
    drain("R6 unarmed drained");

    // R7: entry past the last valid slot issues nothing
    do_redirect();
    send(pkt(1'b1, 2'd2, 8'h61, 8'h62, 8'h63));
    drain("R7 two-slot entry 2 empty");
    do_redirect();
    send(pkt(1'b0, 2'd3, 8'h71, 8'h72, 8'h73));
    drain("R7 entry 3 empty");

    // R8: redirect mid-packet
    push(model[8'h81], "R8 slot before redirect");
    send(pkt(1'b0, 2'd0, 8'h81, 8'h82, 8'h83));
    @(negedge clk);
    do_redirect();
    check(!instr_valid && fetch_req, "R8 squash and refetch",
          {30'd0, instr_valid, fetch_req}, 32'd1);
    push(model[8'h91], "R8 restart A");
    push(model[8'h92], "R8 restart B");
    send(pkt(1'b1, 2'd0, 8'h91, 8'h92, 8'h93));
    drain("R8 drained");

    // R9: rewrite one entry and read it back three times
    dict_we = 1'b1; dict_waddr = 8'h07; dict_wdata = 32'hCAFE_0707;
    @(negedge clk);
    dict_we = 1'b0;
    model[7] = 32'hCAFE_0707;
    push(model[7], "R9 rewritten A");
    push(model[7], "R9 rewritten B");
    push(model[7], "R9 rewritten C");
    send(pkt(1'b0, 2'd0, 8'h07, 8'h07, 8'h07));
    drain("R9 drained");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule